// File: doc/BRIEF.md
# Sectored Decoded Instruction Cache

This block is a small store of instructions that have already been decoded. It serves a single-issue, in-order fetch path. When a fetch address hits, the stored decoded word is returned directly, so that fetch needs neither an instruction-cache read nor a pass through the decoder.

Capacity is 512 bytes of decoded words. Storage is grouped into sectors. Each sector is a run of neighboring lines that share one tag. Every instruction slot has its own valid bit. Sectors are placed by a direct-mapped index.

The decode stage offers each decoded instruction through a fill port. Only instructions whose decoded form fits the narrow stored width are accepted; this is the cacheable class. A fill whose tag differs from the tag of its sector takes over that sector and discards everything the sector held. A synchronous flush empties the whole cache in one cycle.

Top module: `decoded_sector_cache`

## Requirements
- R1: After reset, a lookup to any address reports no hit.
- R2: A lookup presented in cycle t gives its result on `lk_hit`/`lk_data` after the clock edge that ends cycle t. After a cycle without `lk_en`, `lk_hit` is 0.
- R3: After a cacheable fill to an address, a lookup to that address hits and returns bits [WORD_W-1:0] of the filled decoded word, until the slot is evicted or flushed.
- R4: A fill is cacheable only when bits [FULL_W-1:WORD_W] of `fill_dec` are all zero. An uncacheable fill changes nothing: an empty slot stays a miss, and a valid slot keeps its old word.
- R5: Each slot is valid on its own. Filling one slot makes no other slot hit, whether in the same line or in a neighboring line of the sector.
- R6: A fill to a sector whose stored tag differs replaces the tag and clears every valid bit of that sector before it sets the filled slot. Earlier addresses in that sector then miss.
- R7: Sectors are independent. A fill or a replacement in one sector never changes hits in another sector.
- R8: When a fill and a lookup address the same slot in the same cycle, the lookup returns the contents from before the fill.
- R9: `flush` clears all valid bits in one cycle and takes precedence over a fill in the same cycle. A lookup in the flush cycle still sees the old contents.
- R10: `lk_data` is all zeros whenever `lk_hit` is 0.
- R11: The address map is fixed. Bits [1:0] are ignored. Bits [4:2] select the slot in a line, bits [6:5] select the line in a sector, and bits [8:7] select the sector. The bits above bit 8 form the tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every slot |
| fill_en | input | 1 | Fill request from decode |
| fill_addr | input | ADDR_W | Byte address of the filled instruction |
| fill_dec | input | FULL_W | Full-width decoded instruction |
| lk_en | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Fetch byte address to look up |
| lk_hit | output | 1 | Registered hit for the previous lookup |
| lk_data | output | WORD_W | Stored decoded word on hit, zero on miss |

## Verification
The bench builds the cache with a 12-bit address, which leaves a 3-bit tag, and keeps the default geometry of 4 sectors × 4 lines × 8 slots. With only 128 slots, every slot can be filled and looked up in sweeps. Sector aliasing by tag can be provoked at will. Same-cycle fill/lookup and flush/fill collisions can be placed on chosen slots while a bench-side model tracks the expected tag and valid bits.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned DEF_FULL_W  = 40;
  localparam int unsigned DEF_SLOTS   = 8;
  localparam int unsigned DEF_LINES   = 4;
  localparam int unsigned DEF_SECTORS = 4;

  // per-sector update selected each cycle
  typedef enum logic [1:0] {
    UPD_NONE,
    UPD_SET,
    UPD_REPLACE,
    UPD_FLUSH
  } upd_e;
endpackage

// File: rtl/dsc_classify.sv
module dsc_classify #(
  parameter int unsigned FULL_W = 40,
  parameter int unsigned WORD_W = 32
) (
  input  logic [FULL_W-1:0] dec,
  output logic              fits
);
  generate
    if (FULL_W > WORD_W) begin : g_narrow
      assign fits = ~|dec[FULL_W-1:WORD_W];
    end else begin : g_all
      assign fits = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dsc_tag_store.sv
module dsc_tag_store
  import dsc_pkg::*;
#(
  parameter int unsigned SECTORS = 4,
  parameter int unsigned PER_SEC = 32,
  parameter int unsigned TAG_W   = 23,
  parameter int unsigned SEC_W   = 2,
  parameter int unsigned SS_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [SEC_W-1:0] wr_sec,
  input  logic [SS_W-1:0]  wr_ss,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             rd_en,
  input  logic [SEC_W-1:0] rd_sec,
  input  logic [SS_W-1:0]  rd_ss,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             hit_q
);
  logic [TAG_W-1:0]   tag_q [SECTORS];
  logic [PER_SEC-1:0] vld_q [SECTORS];
  upd_e               upd   [SECTORS];

  always_comb begin
    for (int s = 0; s < SECTORS; s++) begin
      upd[s] = UPD_NONE;
      if (flush)
        upd[s] = UPD_FLUSH;
      else if (wr_en && (wr_sec == SEC_W'(s)))
        upd[s] = (tag_q[s] == wr_tag) ? UPD_SET : UPD_REPLACE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SECTORS; s++) begin
        tag_q[s] <= '0;
        vld_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SECTORS; s++) begin
        case (upd[s])
          UPD_FLUSH:   vld_q[s] <= '0;
          UPD_SET:     vld_q[s][wr_ss] <= 1'b1;
          UPD_REPLACE: begin
            tag_q[s] <= wr_tag;
            vld_q[s] <= PER_SEC'(1) << wr_ss;
          end
          default: ;
        endcase
      end
    end
  end

  // lookup reads state before this cycle's update
  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= rd_en && (tag_q[rd_sec] == rd_tag) && vld_q[rd_sec][rd_ss];
  end
endmodule

// File: rtl/dsc_data_ram.sv
module dsc_data_ram #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned AW     = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata_q
);
  logic [WORD_W-1:0] mem [DEPTH];

  // read-first: a same-address write is seen on the following read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/decoded_sector_cache.sv
module decoded_sector_cache
  import dsc_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned WORD_W  = DEF_WORD_W,
  parameter int unsigned FULL_W  = DEF_FULL_W,
  parameter int unsigned SLOTS   = DEF_SLOTS,
  parameter int unsigned LINES   = DEF_LINES,
  parameter int unsigned SECTORS = DEF_SECTORS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [FULL_W-1:0] fill_dec,
  input  logic              lk_en,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [WORD_W-1:0] lk_data
);
  // SLOTS, LINES, SECTORS: powers of two, SECTORS >= 2
  localparam int unsigned OFS_W   = $clog2(WORD_W / 8);
  localparam int unsigned SLOT_W  = $clog2(SLOTS);
  localparam int unsigned LINE_W  = $clog2(LINES);
  localparam int unsigned SEC_W   = $clog2(SECTORS);
  localparam int unsigned SS_W    = SLOT_W + LINE_W;
  localparam int unsigned IDX_W   = SS_W + SEC_W;
  localparam int unsigned TAG_LSB = OFS_W + IDX_W;
  localparam int unsigned TAG_W   = ADDR_W - TAG_LSB;
  localparam int unsigned PER_SEC = SLOTS * LINES;
  localparam int unsigned DEPTH   = PER_SEC * SECTORS;

  logic              fits;
  logic              accept;
  logic [WORD_W-1:0] ram_q;
  logic              hit_q;

  wire [IDX_W-1:0] f_idx = fill_addr[TAG_LSB-1:OFS_W];
  wire [IDX_W-1:0] l_idx = lk_addr[TAG_LSB-1:OFS_W];
  wire [TAG_W-1:0] f_tag = fill_addr[ADDR_W-1:TAG_LSB];
  wire [TAG_W-1:0] l_tag = lk_addr[ADDR_W-1:TAG_LSB];

  dsc_classify #(.FULL_W(FULL_W), .WORD_W(WORD_W)) u_cls (
    .dec  (fill_dec),
    .fits (fits)
  );

  assign accept = fill_en && fits && !flush;

  dsc_tag_store #(
    .SECTORS (SECTORS),
    .PER_SEC (PER_SEC),
    .TAG_W   (TAG_W),
    .SEC_W   (SEC_W),
    .SS_W    (SS_W)
  ) u_tags (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .wr_en  (accept),
    .wr_sec (f_idx[IDX_W-1:SS_W]),
    .wr_ss  (f_idx[SS_W-1:0]),
    .wr_tag (f_tag),
    .rd_en  (lk_en),
    .rd_sec (l_idx[IDX_W-1:SS_W]),
    .rd_ss  (l_idx[SS_W-1:0]),
    .rd_tag (l_tag),
    .hit_q  (hit_q)
  );

  dsc_data_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(IDX_W)) u_ram (
    .clk     (clk),
    .we      (accept),
    .waddr   (f_idx),
    .wdata   (fill_dec[WORD_W-1:0]),
    .re      (lk_en),
    .raddr   (l_idx),
    .rdata_q (ram_q)
  );

  assign lk_hit  = hit_q;
  assign lk_data = hit_q ? ram_q : '0;
endmodule

// File: rtl/dsc_chk.sv
module dsc_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FULL_W  = 40,
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned LINES   = 4,
  parameter int unsigned SECTORS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              fill_en,
  input logic [ADDR_W-1:0] fill_addr,
  input logic [FULL_W-1:0] fill_dec,
  input logic              lk_en,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic [WORD_W-1:0] lk_data
);
  localparam int unsigned OFS_W = $clog2(WORD_W / 8);
  localparam int unsigned SS_W  = $clog2(SLOTS) + $clog2(LINES);
  localparam int unsigned SEC_W = $clog2(SECTORS);
  localparam int unsigned WA_W  = ADDR_W - OFS_W;
  localparam int unsigned TLO   = SS_W + SEC_W;

  wire            ok_c = fill_en && ((fill_dec >> WORD_W) == '0) && !flush;
  wire [WA_W-1:0] f_wa = fill_addr[ADDR_W-1:OFS_W];
  wire [WA_W-1:0] l_wa = lk_addr[ADDR_W-1:OFS_W];

  logic              ok1, ok2, fl1;
  logic [WA_W-1:0]   a1, a2;
  logic [WORD_W-1:0] d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ok1 <= 1'b0; ok2 <= 1'b0; fl1 <= 1'b0;
      a1 <= '0; a2 <= '0; d1 <= '0;
    end else begin
      ok1 <= ok_c;
      a1  <= f_wa;
      d1  <= fill_dec[WORD_W-1:0];
      ok2 <= ok1;
      a2  <= a1;
      fl1 <= flush;
    end
  end

  wire evict_pair = ok1 && ok2 &&
                    (a1[TLO-1:SS_W] == a2[TLO-1:SS_W]) &&
                    (a1[WA_W-1:TLO] != a2[WA_W-1:TLO]);

  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_en)); // R2

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    (lk_en && ok1 && (l_wa == a1)) |=> (lk_hit && (lk_data == $past(d1)))); // R3

  AST_SECTOR_EVICT: assert property (@(posedge clk) disable iff (rst)
    (lk_en && evict_pair && (l_wa == a2)) |=> !lk_hit); // R6

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (lk_en && fl1) |=> !lk_hit); // R9
endmodule

bind decoded_sector_cache dsc_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .FULL_W(FULL_W),
  .SLOTS(SLOTS), .LINES(LINES), .SECTORS(SECTORS)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .fill_en(fill_en),
  .fill_addr(fill_addr), .fill_dec(fill_dec), .lk_en(lk_en),
  .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data)
);

// File: tb/sim_decoded_sector_cache.sv
module sim_decoded_sector_cache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int WW = 32;
  localparam int FW = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic          fill_en = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [FW-1:0] fill_dec = '0;
  logic          lk_en = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          lk_hit;
  logic [WW-1:0] lk_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the cache contents
  logic [2:0]    mtag [4];
  logic [31:0]   mval [4];
  logic [WW-1:0] mdat [128];

  always #(CLK_PERIOD / 2) clk = ~clk;

  decoded_sector_cache #(.ADDR_W(AW), .WORD_W(WW), .FULL_W(FW)) u0 (
    .clk(clk), .rst(rst), .flush(flush), .fill_en(fill_en),
    .fill_addr(fill_addr), .fill_dec(fill_dec), .lk_en(lk_en),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data)
  );

  function automatic logic [AW-1:0] mk(input int tag, input int idx, input int ofs);
    return AW'((tag << 9) | ((idx & 127) << 2) | (ofs & 3));
  endfunction

  // one cycle: drive at a falling edge, check at the next falling edge
  task automatic step(input logic f_en, input logic [AW-1:0] fa, input logic [FW-1:0] fd,
                      input logic l_en, input logic [AW-1:0] la, input logic fl,
                      input string req);
    logic          eh;
    logic [WW-1:0] ed;
    int ls, lss, fs, fss;
    ls  = int'(la[8:7]);  lss = int'(la[6:2]);
    fs  = int'(fa[8:7]);  fss = int'(fa[6:2]);
    fill_en = f_en; fill_addr = fa; fill_dec = fd;
    lk_en = l_en; lk_addr = la; flush = fl;
    eh = l_en && (mtag[ls] == la[11:9]) && mval[ls][lss];
    ed = eh ? mdat[int'(la[8:2])] : '0;
    if (fl) begin
      for (int s = 0; s < 4; s++) mval[s] = '0;
    end else if (f_en && (fd[FW-1:WW] == '0)) begin
      if (mtag[fs] != fa[11:9]) begin
        mtag[fs] = fa[11:9];
        mval[fs] = '0;
      end
      mval[fs][fss] = 1'b1;
      mdat[int'(fa[8:2])] = fd[WW-1:0];
    end
    @(negedge clk);
    fill_en = 1'b0; lk_en = 1'b0; flush = 1'b0;
    checks++;
    if (lk_hit !== eh || lk_data !== ed) begin
      fails++;
      $display("FAIL %s addr=%h: hit=%b data=%h expected hit=%b data=%h",
               req, la, lk_hit, lk_data, eh, ed);
    end
  endtask

  task automatic fill(input logic [AW-1:0] fa, input logic [FW-1:0] fd, input string req);
    step(1'b1, fa, fd, 1'b0, '0, 1'b0, req);
  endtask

  task automatic look(input logic [AW-1:0] la, input string req);
    step(1'b0, '0, '0, 1'b1, la, 1'b0, req);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin mtag[s] = '0; mval[s] = '0; end
    for (int i = 0; i < 128; i++) mdat[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, R10 zero data on miss
    look(mk(0, 0, 0), "R1");
    look(mk(3, 105, 1), "R1");
    look(mk(7, 127, 3), "R10");

    // R3 / R11: fill all 128 slots of tag 1, read back with varied byte offsets
    for (int i = 0; i < 128; i++) fill(mk(1, i, 0), FW'(i * 37 + 5), "R3");
    for (int i = 0; i < 128; i++) look(mk(1, i, i), "R11");
    for (int i = 0; i < 16; i++) look(mk(2, i * 8, 0), "R11");

    // R2: idle cycle gives no hit
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, "R2");

    // R9: flush with a concurrent fill, lookup sees old contents that cycle
    step(1'b1, mk(1, 7, 0), 40'h00_dead_beef, 1'b1, mk(1, 7, 0), 1'b1, "R9");
    for (int i = 0; i < 128; i++) look(mk(1, i, 0), "R9");

    // R5 / R7: one slot filled, every other slot misses
    fill(mk(1, 45, 0), 40'h00_1234_5678, "R5");
    for (int i = 0; i < 128; i++) look(mk(1, i, 0), "R5");

    // R4: uncacheable fills are dropped
    fill(mk(1, 46, 0), 40'h01_0000_0001, "R4");
    look(mk(1, 46, 0), "R4");
    fill(mk(1, 45, 0), 40'h80_aaaa_aaaa, "R4");
    look(mk(1, 45, 0), "R4");

    // R6 / R7: tag conflict inside sector 1, sector 0 untouched
    fill(mk(1, 10, 0), 40'h00_0000_0a0a, "R7");
    fill(mk(1, 40, 0), 40'h00_0000_4040, "R6");
    fill(mk(3, 33, 0), 40'h00_3333_3333, "R6");
    look(mk(1, 45, 0), "R6");
    look(mk(1, 40, 0), "R6");
    look(mk(3, 33, 0), "R6");
    look(mk(3, 45, 0), "R6");
    look(mk(1, 10, 0), "R7");
    for (int i = 0; i < 128; i++) look(mk(3, i, 0), "R7");

    // R8: fill and lookup of the same slot in one cycle
    step(1'b1, mk(3, 34, 0), 40'h00_0000_3434, 1'b1, mk(3, 34, 0), 1'b0, "R8");
    look(mk(3, 34, 0), "R8");
    step(1'b1, mk(3, 34, 0), 40'h00_0000_4343, 1'b1, mk(3, 34, 0), 1'b0, "R8");
    look(mk(3, 34, 0), "R8");

    // R7: back-to-back replacements across all sectors
    for (int i = 0; i < 128; i++) fill(mk(i % 8, i, 0), FW'(i ^ 32'h5a5a), "R7");
    for (int i = 0; i < 128; i++) look(mk(i % 8, i, 0), "R7");
    for (int i = 0; i < 128; i += 9) look(mk((i + 1) % 8, i, 0), "R6");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule